// File: doc/BRIEF.md
# Prescaled Capture Timer

This block is a 16-bit free-running counter with a set of capture channels, reached through a small byte-wide register port. The counter advances on a count enable. That enable comes from a divider on the bus clock, with seven power-of-two ratios, or from rising edges on an external clock pin. A 3-bit select in the timer control byte picks the source.

Each channel watches one input pin. When the pin makes the transition the channel is programmed for, the channel copies the counter into its own 16-bit capture register and raises a flag. A channel whose interrupt enable is set then drives the combined interrupt output. Software clears a flag in two steps: it reads the channel status byte while the flag is set, then writes that byte with the flag bit at 0.

Each channel status byte also holds mode, toggle and max bits. These are stored and read back, but they change nothing here. All pins pass through a two-flop synchronizer, so a pin edge reaches a capture two bus clocks after it is first sampled.

Top module: `cap_timer`

## Requirements
- R1: After reset the control byte, every channel status byte and the interrupt output read 0, and the counter starts from 0 (its high byte reads 0 just after reset).
- R2: The counter changes only on a count enable. On each enable it steps by exactly one and wraps from 0xFFFF to 0x0000.
- R3: A select code k from 0 to 6 (control byte at address 0, bits 2..0) advances the counter once every 2^k bus clocks. The counter reads at address 1 (bits 15..8) and address 2 (bits 7..0).
- R4: Select code 7 advances the counter once per synchronized rising edge of the external clock pin. The counter holds while that pin stays at one level.
- R5: The edge select is status bits 3..2: 00 never captures, 01 captures on rising edges, 10 on falling edges, 11 on both.
- R6: A qualifying edge latches the counter into the channel's register pair. Channel i has its status byte at 4+4i, the capture high byte (bits 15..8) at 5+4i and the low byte (bits 7..0) at 6+4i. The difference between two captures equals the bus clocks between the two pin edges when the select code is 0.
- R7: Status bits 6..0 (6 interrupt enable, 5..4 mode, 3..2 edge, 1 toggle, 0 max) are written and read back as stored. Writing 1 to bit 7 (the flag) does not set it.
- R8: On the last channel, status bit 5 is reserved and always reads 0.
- R9: A flag clears only when a status write with bit 7 = 0 follows a read of that status byte taken while the flag was set. A write with no such read leaves the flag set.
- R10: If a capture lands in the same cycle as a clearing write, the flag stays set.
- R11: The interrupt output is 1, one cycle after the fact, when any channel has both its flag and its interrupt enable set. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (5) | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe; rdata valid the next cycle |
| rdata | output | 8 | Registered read data |
| ext_clk_pin | input | 1 | External count clock pin (asynchronous) |
| cap_pin | input | NUM_CH (4) | Capture input pins (asynchronous) |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The counter is checked under each divide code by reading it twice a fixed multiple of the ratio apart, so that every code gives a delta of exactly eight. The external source is checked by counting pulses and then holding the pin. Capture is exercised with rising-only, falling-only, both-edge and disabled selections, each driven with both pin directions, which separates a wrong polarity from a missing capture. Flag clearing is tried three ways: without the preceding read, with it, and with a capture timed onto the clearing write. These separate a missing arm condition from a lost capture. The interrupt output is tested with the enable set and cleared.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int TMR_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      flag;
    logic      ie;
    logic      mode_b;
    logic      mode_a;
    edge_sel_e edge_sel;
    logic      tgl;
    logic      maxed;
  } ch_stat_t;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int PS_W   = 3,
  parameter int CNT_W  = 16,
  parameter int STAGES = 2,
  localparam int EXT_CODE = (1 << PS_W) - 1,
  localparam int PRE_W    = EXT_CODE - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PS_W-1:0]  ps,
  input  logic             ext_pin,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;
  logic             ext_rise;
  logic             ext_fall;

  cap_sync #(.STAGES(STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .rise(ext_rise), .fall(ext_fall)
  );

  always_comb begin
    mask = '0;
    for (int k = 0; k < PRE_W; k++) begin
      if (k < int'(ps)) mask[k] = 1'b1;
    end
    if (int'(ps) == EXT_CODE) tick = ext_rise;
    else                      tick = ((pre & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  logic unused_fall;
  assign unused_fall = ext_fall;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_timer_pkg::*;
#(
  parameter int    STAGES  = 2,
  parameter bit    HAS_MSB = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin,
  input  logic [TMR_W-1:0]  cnt,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] stat,
  output logic [TMR_W-1:0]  cap,
  output logic              evt
);
  ch_stat_t st;
  logic     arm;
  logic     rise;
  logic     fall;
  logic     flag_nxt;

  cap_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(pin), .rise(rise), .fall(fall)
  );

  always_comb begin
    unique case (st.edge_sel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_ANY:  evt = rise | fall;
      default:   evt = 1'b0;
    endcase
    flag_nxt = st.flag;
    if (wr_stat && arm && !wdata[7]) flag_nxt = 1'b0;
    if (evt) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= '0;
      arm <= 1'b0;
    end else begin
      st.flag <= flag_nxt;
      if (wr_stat) begin
        st.ie       <= wdata[6];
        st.mode_b   <= HAS_MSB ? wdata[5] : 1'b0;
        st.mode_a   <= wdata[4];
        st.edge_sel <= edge_sel_e'(wdata[3:2]);
        st.tgl      <= wdata[1];
        st.maxed    <= wdata[0];
        arm         <= 1'b0;
      end else if (rd_stat && st.flag) begin
        arm <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (evt) cap <= cnt;
  end

  assign stat = st;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PS_W   = 3,
  parameter int STAGES = 2,
  localparam int ADDR_W = $clog2((NUM_CH + 1) * 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic              ext_clk_pin,
  input  logic [NUM_CH-1:0] cap_pin,
  output logic              irq
);
  localparam int SEL_W = ADDR_W - 2;

  logic [PS_W-1:0]   ps_q;
  logic              cnt_tick;
  logic [TMR_W-1:0]  cnt_val;
  logic [NUM_CH-1:0] st_hit;
  logic [NUM_CH-1:0] st_wr;
  logic [NUM_CH-1:0] st_rd;
  logic [NUM_CH-1:0] ch_evt;
  logic [NUM_CH-1:0] ch_flag;
  logic [NUM_CH-1:0] ch_ie;
  logic [7:0]        ch_stat [NUM_CH];
  logic [TMR_W-1:0]  ch_cap  [NUM_CH];
  logic [7:0]        rd_mux;

  cap_timebase #(.PS_W(PS_W), .CNT_W(TMR_W), .STAGES(STAGES)) u_tb (
    .clk(clk), .rst(rst), .ps(ps_q), .ext_pin(ext_clk_pin),
    .tick(cnt_tick), .cnt(cnt_val)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign st_hit[i]  = (addr[ADDR_W-1:2] == SEL_W'(i + 1)) && (addr[1:0] == 2'd0);
    assign st_wr[i]   = wr_en && st_hit[i];
    assign st_rd[i]   = rd_en && st_hit[i];
    assign ch_flag[i] = ch_stat[i][7];
    assign ch_ie[i]   = ch_stat[i][6];

    cap_channel #(.STAGES(STAGES), .HAS_MSB(i != NUM_CH - 1)) u_ch (
      .clk(clk), .rst(rst), .pin(cap_pin[i]), .cnt(cnt_val),
      .wr_stat(st_wr[i]), .rd_stat(st_rd[i]), .wdata(wdata),
      .stat(ch_stat[i]), .cap(ch_cap[i]), .evt(ch_evt[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr[ADDR_W-1:2] == '0) begin
      unique case (addr[1:0])
        2'd0:    rd_mux = 8'(ps_q);
        2'd1:    rd_mux = cnt_val[15:8];
        2'd2:    rd_mux = cnt_val[7:0];
        default: rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr[ADDR_W-1:2] == SEL_W'(i + 1)) begin
          unique case (addr[1:0])
            2'd0:    rd_mux = ch_stat[i];
            2'd1:    rd_mux = ch_cap[i][15:8];
            2'd2:    rd_mux = ch_cap[i][7:0];
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q  <= '0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= |(ch_flag & ch_ie);
      if (rd_en) rdata <= rd_mux;
      if (wr_en && addr == '0) ps_q <= wdata[PS_W-1:0];
    end
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [15:0]       cnt,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] ies,
  input logic [NUM_CH-1:0] cap_evt,
  input logic [NUM_CH-1:0] clr_wr,
  input logic              irq,
  input logic              last_rsv
);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == 16'($past(cnt) + 16'd1));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  p_irq_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(flags & ies)));

  p_rsv_r8: assert property (@(posedge clk) disable iff (rst)
    !last_rsv);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
      cap_evt[i] |=> flags[i]);
    p_flag_keep_r9: assert property (@(posedge clk) disable iff (rst)
      flags[i] && !clr_wr[i] |=> flags[i]);
  end
endmodule

bind cap_timer cap_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .tick(cnt_tick), .cnt(cnt_val),
  .flags(ch_flag), .ies(ch_ie), .cap_evt(ch_evt), .clr_wr(st_wr),
  .irq(irq), .last_rsv(ch_stat[NUM_CH-1][5])
);

// File: tb/cap_timer_tb.sv
`timescale 1ns/1ps
module cap_timer_tb;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [7:0]        rdata;
  logic              ext_clk_pin = 1'b0;
  logic [NUM_CH-1:0] cap_pin = '0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cap_timer #(.NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .ext_clk_pin(ext_clk_pin),
    .cap_pin(cap_pin), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = ADDR_W'(a); rd_en = 1'b1;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); check("R1 ctrl", d, 0);
    for (int i = 0; i < NUM_CH; i++) begin
      rd(4 + 4 * i, d); check("R1 status", d, 0);
    end
    rd(1, d); check("R1 counter high", d, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_prescale;
    logic [7:0] a, b;
    for (int k = 0; k < 7; k++) begin
      wr(0, 8'(k));
      rd(2, a);
      wait_cyc((8 << k) - 1);
      rd(2, b);
      check($sformatf("R3 code %0d delta", k), int'(8'(b - a)), 8);
    end
    wr(0, 8'd0);
  endtask

  task automatic t_external;
    logic [7:0] a, b, c;
    wr(0, 8'd7);
    rd(2, a);
    for (int p = 0; p < 5; p++) begin
      ext_clk_pin = 1'b1; wait_cyc(3);
      ext_clk_pin = 1'b0; wait_cyc(3);
    end
    wait_cyc(4);
    rd(2, b);
    check("R4 ext pulses", int'(8'(b - a)), 5);
    ext_clk_pin = 1'b1; wait_cyc(4);
    rd(2, a);
    wait_cyc(20);
    rd(2, c);
    check("R4 ext held", int'(8'(c - a)), 0);
    ext_clk_pin = 1'b0; wait_cyc(4);
    wr(0, 8'd0);
  endtask

  task automatic t_layout;
    logic [7:0] d;
    wr(4, 8'hFF); rd(4, d); check("R7 readback no flag set", d, 8'h7F);
    wr(4, 8'h00); rd(4, d); check("R7 clear back", d, 8'h00);
    wr(16, 8'hFF); rd(16, d); check("R8 reserved bit", d, 8'h5F);
    wr(16, 8'h00);
  endtask

  task automatic t_capture;
    logic [7:0] h1, l1, h2, l2, d;
    wr(4, 8'h3C);
    cap_pin[0] = 1'b1; wait_cyc(5);
    rd(5, h1); rd(6, l1);
    wait_cyc(3);
    cap_pin[0] = 1'b0; wait_cyc(5);
    rd(5, h2); rd(6, l2);
    check("R6 capture delta", int'(16'({h2, l2} - {h1, l1})), 10);
    wr(4, 8'h3C);
    rd(4, d); check("R9 no clear without read", d, 8'hBC);
    wr(4, 8'h3C);
    rd(4, d); check("R9 clear after read", d, 8'h3C);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    wr(8, 8'h04);
    cap_pin[1] = 1'b1; wait_cyc(5);
    rd(8, d); check("R5 rise on rise", d, 8'h84);
    wr(8, 8'h04);
    cap_pin[1] = 1'b0; wait_cyc(5);
    rd(8, d); check("R5 rise ignores fall", d, 8'h04);
    wr(8, 8'h08);
    cap_pin[1] = 1'b1; wait_cyc(5);
    rd(8, d); check("R5 fall ignores rise", d, 8'h08);
    cap_pin[1] = 1'b0; wait_cyc(5);
    rd(8, d); check("R5 fall on fall", d, 8'h88);
    wr(8, 8'h00);
    rd(8, d); check("R5 cleared", d, 8'h00);
    cap_pin[1] = 1'b1; wait_cyc(5);
    cap_pin[1] = 1'b0; wait_cyc(5);
    rd(8, d); check("R5 disabled", d, 8'h00);
    wr(8, 8'h0C);
    cap_pin[1] = 1'b1; wait_cyc(5);
    rd(8, d); check("R5 both on rise", d, 8'h8C);
    wr(8, 8'h0C);
    cap_pin[1] = 1'b0; wait_cyc(5);
    rd(8, d); check("R5 both on fall", d, 8'h8C);
    wr(8, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] d;
    cap_pin[0] = 1'b1; wait_cyc(5);
    rd(4, d); check("R10 flag up", d, 8'hBC);
    cap_pin[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    wr(4, 8'h3C);
    wait_cyc(2);
    rd(4, d); check("R10 capture wins", d, 8'hBC);
    wr(4, 8'h3C);
    rd(4, d); check("R10 later clear", d, 8'h3C);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(12, 8'h44);
    wait_cyc(2);
    check("R11 idle", irq, 0);
    cap_pin[2] = 1'b1; wait_cyc(5);
    check("R11 raised", irq, 1);
    rd(12, d);
    wr(12, 8'h44);
    wait_cyc(2);
    check("R11 dropped", irq, 0);
    wr(12, 8'h04);
    cap_pin[2] = 1'b0; wait_cyc(2);
    cap_pin[2] = 1'b1; wait_cyc(5);
    rd(12, d); check("R11 flag without enable", d, 8'h84);
    check("R11 masked", irq, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    t_reset;
    t_prescale;
    t_external;
    t_layout;
    t_capture;
    t_edges;
    t_race;
    t_irq;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule